// File: doc/BRIEF.md
# Nine-bit SPI word transmitter with byte-link emulation

This block turns a stream of display controller bytes into serial words of nine bits. Each word carries a data/command flag and then the eight payload bits. A host presents one byte per handshake, together with a flag that marks it as a command or as data and a marker for the last byte of a transaction. The block drives the serial clock, the data line and an active-low chip select.

The block has two framing modes, chosen by an input that is sampled when a transaction starts. In native mode every word goes out as its own nine-clock frame. In emulation mode the same bit stream goes out in eight-clock frames, so a link that can only move whole bytes still carries nine-bit words: eight words (72 bits) fill exactly nine byte frames. When a transaction ends part way through a group, the block fills the group with no-operation command words before it releases chip select.

The serial clock runs at half the system clock and follows SPI mode 0. Between frames the clock idles low for a configurable number of bit times. The clock may also stall low inside a frame while the block waits for the host.

Top module: `ninebit_spi_tx`

## Requirements
- R1: After reset, spi_cs_n is 1, spi_sck is 0, spi_mosi is 0 and in_ready is 1.
- R2: Each word goes out as nine bits, most significant first: the flag first (0 = command byte, 1 = data byte, taken from in_is_data), then in_byte from bit 7 down to bit 0.
- R3: In native mode (mode_emul = 0), each word forms a frame of exactly 9 consecutive serial clock pulses, and frames are separated by an idle gap of GAP_BITS bit times.
- R4: In emulation mode (mode_emul = 1), the word stream is cut into frames of exactly 8 pulses with no gaps between words, and every 8 words fill exactly 9 frames.
- R5: In emulation mode, a transaction whose word count is not a multiple of 8 is padded with words of flag 0 and byte 0x00 until the group is complete, before chip select is released.
- R6: In native mode no padding word is ever sent: a transaction of n words carries exactly 9·n bits.
- R7: spi_cs_n goes low when the first byte is accepted, stays low for the whole transaction, including stalls, and rises only after the final bit of the word marked in_last (or of its padding). No byte is accepted in the cycle after the last byte is taken.
- R8: SPI mode 0 timing holds: spi_mosi never changes on the rising edge of spi_sck, and spi_sck is low whenever spi_cs_n is high.
- R9: mode_emul is sampled only when the first byte of a transaction is accepted. Changes to it later in the same transaction do not change the framing.
- R10: If in_valid drops in the middle of a transaction, the serial clock stalls low without losing or repeating a bit, and the bit stream is the same as for an unbroken input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; the serial clock runs at half this rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_emul | input | 1 | 0 = native nine-bit frames, 1 = byte-frame emulation; sampled at transaction start |
| in_valid | input | 1 | A byte is offered |
| in_ready | output | 1 | The block takes the offered byte on this clock edge |
| in_byte | input | PAY_W | Payload byte |
| in_is_data | input | 1 | Word flag: 0 = command, 1 = data |
| in_last | input | 1 | Marks the final byte of a transaction |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data, most significant bit first |
| spi_cs_n | output | 1 | Chip select, active low |

## Verification
The assertions assume the host holds in_byte, in_is_data, in_last and in_valid steady from one falling clock edge to the next. They also assume every transaction ends with a byte that has in_last set, and that in_valid is never offered without a byte behind it. The bench changes inputs only on falling edges and finishes every transaction with a last-marked byte. Its stall test holds in_valid low for longer than one word time, so the block has to stall mid-word. The mode-change test flips mode_emul only after the first byte has been accepted.

// File: rtl/nbt_pkg.sv
package nbt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_GAP   = 2'd2,
    ST_WAIT  = 2'd3
  } nbt_state_t;

endpackage

// File: rtl/nbt_shifter.sv
module nbt_shifter #(
  parameter int WORD_W = 9,
  localparam int BCW = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic              shift,
  output logic              msb,
  output logic [BCW-1:0]    bits_left
);

  logic [WORD_W-1:0] sh_q, sh_d;
  logic [BCW-1:0]    cnt_q, cnt_d;
  logic              en;

  assign en = load | shift;

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    if (load) begin
      sh_d  = load_word;
      cnt_d = BCW'(WORD_W);
    end else if (shift) begin
      sh_d  = {sh_q[WORD_W-2:0], 1'b0};
      cnt_d = (cnt_q == '0) ? '0 : cnt_q - BCW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (en) begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
    end
  end

  assign msb       = sh_q[WORD_W-1];
  assign bits_left = cnt_q;

endmodule

// File: rtl/nbt_framer.sv
module nbt_framer #(
  parameter int PAY_W    = 8,
  parameter int GAP_BITS = 1,
  localparam int WORD_W  = PAY_W + 1,
  localparam int FCW     = $clog2(WORD_W + 1),
  localparam int GAP_CYC = 2 * GAP_BITS,
  localparam int GCW     = $clog2(GAP_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic emul,
  input  logic bit_done,
  input  logic in_gap,
  output logic frame_end,
  output logic gap_done
);

  logic [FCW-1:0] fbits_q, fbits_d;
  logic [FCW-1:0] frame_len;
  logic [GCW-1:0] gcnt_q, gcnt_d;
  logic           fb_en;

  assign frame_len = emul ? FCW'(PAY_W) : FCW'(WORD_W);
  assign frame_end = bit_done && (fbits_q == frame_len - FCW'(1));
  assign gap_done  = in_gap && (gcnt_q == GCW'(GAP_CYC - 1));
  assign fb_en     = clr | bit_done;

  always_comb begin
    if (clr)            fbits_d = '0;
    else if (frame_end) fbits_d = '0;
    else                fbits_d = fbits_q + FCW'(1);
  end

  always_comb begin
    if (!in_gap || gap_done) gcnt_d = '0;
    else                     gcnt_d = gcnt_q + GCW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fbits_q <= '0;
      gcnt_q  <= '0;
    end else begin
      if (fb_en) fbits_q <= fbits_d;
      gcnt_q <= gcnt_d;
    end
  end

endmodule

// File: rtl/nbt_group.sv
module nbt_group #(
  parameter int PAY_W = 8,
  localparam int GW   = (PAY_W > 1) ? $clog2(PAY_W) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic load,
  output logic group_open
);

  logic [GW-1:0] cnt_q, cnt_d;
  logic [GW-1:0] inc;
  logic          en;

  assign inc = (cnt_q == GW'(PAY_W - 1)) ? '0 : cnt_q + GW'(1);
  assign en  = clr | load;

  always_comb begin
    if (clr) cnt_d = load ? GW'(1) : '0;
    else     cnt_d = inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cnt_q <= '0;
    else if (en) cnt_q <= cnt_d;
  end

  assign group_open = (cnt_q != '0);

endmodule

// File: rtl/ninebit_spi_tx.sv
module ninebit_spi_tx
  import nbt_pkg::*;
#(
  parameter int PAY_W    = 8,
  parameter int GAP_BITS = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_emul,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PAY_W-1:0] in_byte,
  input  logic             in_is_data,
  input  logic             in_last,
  output logic             spi_sck,
  output logic             spi_mosi,
  output logic             spi_cs_n
);

  localparam int WORD_W = PAY_W + 1;
  localparam int BCW    = $clog2(WORD_W + 1);

  nbt_state_t st_q, st_d;
  logic ph_q, ph_d;
  logic emul_q, emul_d;
  logic last_q, last_d;

  logic [BCW-1:0]    bits_left;
  logic              sh_msb;
  logic              frame_end, gap_done, group_open;
  logic              bit_done, word_end, accept, pad_load, finish, load;
  logic [WORD_W-1:0] load_word;
  logic              is_idle, in_gap;

  assign is_idle   = (st_q == ST_IDLE);
  assign in_gap    = (st_q == ST_GAP);
  assign bit_done  = (st_q == ST_SHIFT) && ph_q;
  assign word_end  = bit_done && (bits_left == BCW'(1));
  assign in_ready  = is_idle || (st_q == ST_WAIT) || (word_end && !last_q);
  assign accept    = in_valid && in_ready;
  assign pad_load  = word_end && last_q && emul_q && group_open;
  assign finish    = word_end && last_q && !pad_load;
  assign load      = accept || pad_load;
  assign load_word = pad_load ? '0 : {in_is_data, in_byte};

  nbt_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .load_word (load_word),
    .shift     (bit_done),
    .msb       (sh_msb),
    .bits_left (bits_left)
  );

  nbt_framer #(.PAY_W(PAY_W), .GAP_BITS(GAP_BITS)) u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (is_idle),
    .emul      (emul_q),
    .bit_done  (bit_done),
    .in_gap    (in_gap),
    .frame_end (frame_end),
    .gap_done  (gap_done)
  );

  nbt_group #(.PAY_W(PAY_W)) u_group (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (is_idle),
    .load       (load),
    .group_open (group_open)
  );

  always_comb begin
    st_d   = st_q;
    ph_d   = ph_q;
    emul_d = emul_q;
    last_d = accept ? in_last : last_q;
    unique case (st_q)
      ST_IDLE: begin
        ph_d = 1'b0;
        if (accept) begin
          st_d   = ST_SHIFT;
          emul_d = mode_emul;
        end
      end
      ST_SHIFT: begin
        if (!ph_q) begin
          ph_d = 1'b1;
        end else begin
          ph_d = 1'b0;
          if (finish)                          st_d = ST_IDLE;
          else if (frame_end)                  st_d = ST_GAP;
          else if (word_end && !load)          st_d = ST_WAIT;
          else                                 st_d = ST_SHIFT;
        end
      end
      ST_GAP: begin
        ph_d = 1'b0;
        if (gap_done) st_d = (bits_left != '0) ? ST_SHIFT : ST_WAIT;
      end
      ST_WAIT: begin
        ph_d = 1'b0;
        if (accept) st_d = ST_SHIFT;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      ph_q   <= 1'b0;
      emul_q <= 1'b0;
      last_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      ph_q   <= ph_d;
      emul_q <= emul_d;
      last_q <= last_d;
    end
  end

  assign spi_cs_n = is_idle;
  assign spi_sck  = bit_done;
  assign spi_mosi = (st_q == ST_SHIFT) && sh_msb;

endmodule

// File: rtl/nbt_chk.sv
module nbt_chk (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic in_last,
  input logic spi_sck,
  input logic spi_mosi,
  input logic spi_cs_n
);

  // R8: clock idles low while deselected
  p_sck_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck);

  // R8: data is settled before the rising edge
  p_mosi_setup_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_sck) |-> $stable(spi_mosi));

  // R3: every high phase lasts one system clock
  p_sck_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sck |=> !spi_sck);

  // R7: nothing taken right after the closing byte
  p_no_take_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_last) |=> !in_ready);

  // R7: select drops only when a byte is taken
  p_cs_fall_on_take_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n) |-> $past(in_valid && in_ready));

  // R1: an idle block is ready to start
  p_idle_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> in_ready);

endmodule

bind ninebit_spi_tx nbt_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_last  (in_last),
  .spi_sck  (spi_sck),
  .spi_mosi (spi_mosi),
  .spi_cs_n (spi_cs_n)
);

// File: tb/sim_ninebit_spi_tx.sv
module sim_ninebit_spi_tx;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_emul = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_byte = 8'h00;
  logic       in_is_data = 1'b0;
  logic       in_last = 1'b0;
  logic       spi_sck, spi_mosi, spi_cs_n;

  always #4 clk = ~clk;

  ninebit_spi_tx #(.PAY_W(8), .GAP_BITS(1)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_emul(mode_emul), .in_valid(in_valid),
    .in_ready(in_ready), .in_byte(in_byte), .in_is_data(in_is_data),
    .in_last(in_last), .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // wire monitor, sampled on falling edges
  bit  mbits [0:4095];
  int  mflen [0:511];
  int  nbits = 0, nfr = 0, curlen = 0, cs_rises = 0, viol = 0;
  int  cyc = 0, last_rise = 0;
  logic sck_q = 1'b0, cs_q = 1'b1, mosi_q = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (spi_sck && spi_cs_n) viol++;
      if (spi_sck && !sck_q) begin
        if (spi_mosi != mosi_q) viol++;
        if (nbits < 4096) mbits[nbits] = spi_mosi;
        nbits++;
        if (curlen > 0 && (cyc - last_rise) == 2) curlen++;
        else begin
          if (curlen > 0) begin
            if (nfr < 512) mflen[nfr] = curlen;
            nfr++;
          end
          curlen = 1;
        end
        last_rise = cyc;
      end
      if (spi_cs_n && !cs_q) begin
        if (curlen > 0) begin
          if (nfr < 512) mflen[nfr] = curlen;
          nfr++;
        end
        curlen = 0;
        cs_rises++;
      end
    end
    sck_q  = spi_sck;
    cs_q   = spi_cs_n;
    mosi_q = spi_mosi;
  end

  function automatic logic [7:0] gen_byte(input int seed, input int i);
    return 8'((seed * 29 + i * 53 + 7) & 255);
  endfunction

  function automatic logic gen_flag(input int seed, input int i);
    return ((seed + i) % 3) != 0;
  endfunction

  task automatic send_txn(input bit mode, input int n, input int seed,
                          input bit stall, input bit flip);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (stall && (i % 2 == 1)) begin
        in_valid = 1'b0;
        repeat (25) @(negedge clk);
      end
      in_valid   = 1'b1;
      in_byte    = gen_byte(seed, i);
      in_is_data = gen_flag(seed, i);
      in_last    = (i == n - 1);
      mode_emul  = (flip && i > 0) ? ~mode : mode;
      while (!in_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
    mode_emul = mode;
    while (spi_cs_n !== 1'b1) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // runs one transaction and checks bits, frames and select
  task automatic run_check(input bit mode, input int n, input int seed,
                           input bit stall, input bit flip, input int exp_frames,
                           input bit chk_frames, input string tag);
    int b0, f0, c0, words, ebits, mism, badlen;
    bit eb [0:1023];
    b0 = nbits; f0 = nfr; c0 = cs_rises;
    words = mode ? ((n + 7) / 8) * 8 : n;
    ebits = words * 9;
    for (int w = 0; w < words; w++) begin
      logic [7:0] by;
      logic       fl;
      by = (w < n) ? gen_byte(seed, w) : 8'h00;
      fl = (w < n) ? gen_flag(seed, w) : 1'b0;
      eb[w*9] = fl;
      for (int k = 0; k < 8; k++) eb[w*9 + 1 + k] = by[7-k];
    end
    send_txn(mode, n, seed, stall, flip);
    chk({tag, " bit count R2"}, nbits - b0, ebits);
    mism = 0;
    for (int k = 0; k < ebits && (b0 + k) < 4096; k++)
      if (mbits[b0 + k] != eb[k]) mism++;
    chk({tag, " stream content R2"}, mism, 0);
    chk({tag, " select released once R7"}, cs_rises - c0, 1);
    if (chk_frames) begin
      chk({tag, " frame count R3/R4"}, nfr - f0, exp_frames);
      badlen = 0;
      for (int k = f0; k < nfr && k < 512; k++)
        if (mflen[k] != (mode ? 8 : 9)) badlen++;
      chk({tag, " frame length R3 R4"}, badlen, 0);
    end
  endtask

  // {mode, words[6:0], seed[7:0], expected frames[7:0]}
  localparam logic [23:0] VEC [0:6] = '{
    {1'b0, 7'd1,  8'd3,  8'd1},
    {1'b0, 7'd5,  8'd11, 8'd5},
    {1'b1, 7'd8,  8'd42, 8'd9},
    {1'b1, 7'd3,  8'd77, 8'd9},
    {1'b1, 7'd9,  8'd5,  8'd18},
    {1'b0, 7'd16, 8'd90, 8'd16},
    {1'b1, 7'd1,  8'd200, 8'd9}
  };

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog R7 actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("reset cs_n R1", int'(spi_cs_n), 1);
    chk("reset sck R1", int'(spi_sck), 0);
    chk("reset mosi R1", int'(spi_mosi), 0);
    chk("reset ready R1", int'(in_ready), 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // table walk: R2 R3 R4 R5 R6 R7
    for (int v = 0; v < 7; v++) begin
      run_check(VEC[v][23], int'(VEC[v][22:16]), int'(VEC[v][15:8]), 1'b0, 1'b0,
                int'(VEC[v][7:0]), 1'b1, $sformatf("vec%0d", v));
    end

    // R6: native five words carry 45 bits, no padding
    begin
      int b0;
      b0 = nbits;
      send_txn(1'b0, 5, 61, 1'b0, 1'b0);
      chk("native no pad R6", nbits - b0, 45);
    end

    // R5: emulation two words padded to a full group of 72 bits
    begin
      int b0, ones;
      b0 = nbits;
      send_txn(1'b1, 2, 0, 1'b0, 1'b0);
      chk("emul group size R5", nbits - b0, 72);
      ones = 0;
      for (int k = 18; k < 72; k++) if (mbits[b0 + k]) ones++;
      chk("emul pad words zero R5", ones, 0);
    end

    // R9: mode flipped after first byte, framing follows the start value
    run_check(1'b1, 3, 17, 1'b0, 1'b1, 9, 1'b1, "flip emul R9");
    run_check(1'b0, 4, 23, 1'b0, 1'b1, 4, 1'b1, "flip native R9");

    // R10: stalls inside a transaction keep the stream intact
    run_check(1'b1, 5, 33, 1'b1, 1'b0, 0, 1'b0, "stall emul R10");
    run_check(1'b0, 3, 48, 1'b1, 1'b0, 0, 1'b0, "stall native R10");

    // R8: mode 0 timing over the whole run
    chk("mode0 timing R8", viol, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule